// File: doc/BRIEF.md
# DAC Channel Data-Transfer Controller

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. Software writes conversion data over a simple register write port. Several views let it write one channel right-aligned in 12 bits, left-aligned in 12 bits, or right-aligned in 8 bits. Dual views load both channels in a single write. Each written value lands in a per-channel holding register. The code that drives the analog converter sits in a separate per-channel output register, and the bus cannot reach it.

Each channel chooses how its held value reaches the output. With its trigger disabled, the output follows the holding register one clock later. With its trigger enabled, a 4-bit select picks one of sixteen sources. Source 0 is a self-clearing software trigger bit. Sources 1 to 15 are hardware event lines. A rising edge on the selected source schedules a copy three clocks later. The copy takes whatever the holding register contains at that moment. The full-scale output is reference × code / 4096.

Top module: `dac_xfer_ctrl`

## Requirements
- R1: After reset both output codes and both holding registers are zero and both triggers are disabled, so toggling any hardware event line leaves both codes at zero.
- R2: With a channel's trigger enable clear, a value loaded into its holding register at clock edge w appears on its code output at edge w+1 and not before.
- R3: Single-channel views (word index: A 12-bit right 2, A 12-bit left 3, A 8-bit right 4, B 12-bit right 5, B 12-bit left 6, B 8-bit right 7) load the code from data bits 11:0, from bits 15:4, or as bits 7:0 followed by four zero bits. They leave the other channel untouched.
- R4: Dual views (word index 8: 12-bit right, 9: 12-bit left, 10: 8-bit right) load channel A from the low half-word and channel B from the high half-word in one write. In the 8-bit dual view, A uses byte 0 and B uses byte 1.
- R5: The control word is at index 0. Bit 0 is A's trigger enable and bits 4:1 are A's select. Bit 16 is B's enable and bits 20:17 are B's select. While a channel's enable is set, holding-register writes do not reach its output until a trigger arrives.
- R6: With select k in 1..15, a rising edge on hw_trig[k-1] that is first sampled high at edge t0 updates the code at edge t0+3.
- R7: A source held high causes only one transfer. Edges on hardware lines that are not selected cause none.
- R8: Writing 1 to bit c of the software trigger word (index 1) with select 0 updates channel c (bit 0 = A, bit 1 = B) at the fourth edge after the write edge. The bit clears itself, so a later write fires again.
- R9: A triggered transfer copies the holding-register content at transfer time, including a value written after the trigger edge.
- R10: A second selected edge arriving while a transfer is pending does not cancel it. The first transfer completes, and the second completes three edges after its own edge.
- R11: The output code only ever changes to the prior holding-register value. Writes to unmapped indices 11 to 15 change neither holding registers nor outputs.
- R12: The two channels are independent. A trigger or transfer on one never changes the other's code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Word index of the register written |
| wr_data | input | 32 | Write data |
| hw_trig | input | 15 | Hardware event lines; select k picks bit k-1 |
| code_a | output | 12 | Channel A code to the converter |
| code_b | output | 12 | Channel B code to the converter |

## Verification
A corrupt holding register shows up on the code one edge after the write when the trigger is off, and three edges after the next trigger when it is on. A broken edge detector or delay line shows up as a transfer arriving a cycle early or late. It can also show up as a second transfer while a line is held high, or as a value captured before a late write. The directed scenarios sample the code on each edge around every transfer, so any such error shows as a mismatch within four clocks of its cause.

// File: rtl/dac_xfer_pkg.sv
package dac_xfer_pkg;

  // Word index of each write view on the register port.
  typedef enum logic [3:0] {
    V_CTRL   = 4'd0,
    V_SWTRIG = 4'd1,
    V_A_R12  = 4'd2,
    V_A_L12  = 4'd3,
    V_A_R8   = 4'd4,
    V_B_R12  = 4'd5,
    V_B_L12  = 4'd6,
    V_B_R8   = 4'd7,
    V_D_R12  = 4'd8,
    V_D_L12  = 4'd9,
    V_D_R8   = 4'd10
  } view_e;

  // Data alignment applied to a written half-word.
  typedef enum logic [1:0] {
    F_R12 = 2'd0,
    F_L12 = 2'd1,
    F_R8  = 2'd2
  } fmt_e;

  localparam int NCH      = 2;
  localparam int CH_FIELD = 16;  // control bit stride between channels

endpackage

// File: rtl/dac_regs.sv
module dac_regs
  import dac_xfer_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int SEL_W  = 4,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  localparam int HALF  = DATA_W / 2,
  localparam int BYTE  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [NCH-1:0]              ten,
  output logic [NCH-1:0][SEL_W-1:0]   tsel,
  output logic [NCH-1:0]              sw_trig,
  output logic [NCH-1:0]              ld,
  output logic [NCH-1:0][CODE_W-1:0]  ld_data
);

  function automatic logic [CODE_W-1:0] align(fmt_e f, logic [HALF-1:0] h);
    case (f)
      F_L12:   return h[HALF-1 -: CODE_W];
      F_R8:    return {h[BYTE-1:0], {(CODE_W-BYTE){1'b0}}};
      default: return h[CODE_W-1:0];
    endcase
  endfunction

  view_e                      view;
  fmt_e                       fmt;
  logic                       dual;
  logic [NCH-1:0]             tgt;
  logic                       ctrl_we;
  logic [NCH-1:0]             ten_n;
  logic [NCH-1:0][SEL_W-1:0]  tsel_n;
  logic [NCH-1:0]             sw_n;

  assign view = view_e'(wr_idx);

  // Decode the write into target channels and a format.
  always_comb begin
    fmt  = F_R12;
    dual = 1'b0;
    tgt  = '0;
    case (view)
      V_A_R12: begin tgt = 2'b01; fmt = F_R12; end
      V_A_L12: begin tgt = 2'b01; fmt = F_L12; end
      V_A_R8:  begin tgt = 2'b01; fmt = F_R8;  end
      V_B_R12: begin tgt = 2'b10; fmt = F_R12; end
      V_B_L12: begin tgt = 2'b10; fmt = F_L12; end
      V_B_R8:  begin tgt = 2'b10; fmt = F_R8;  end
      V_D_R12: begin tgt = 2'b11; fmt = F_R12; dual = 1'b1; end
      V_D_L12: begin tgt = 2'b11; fmt = F_L12; dual = 1'b1; end
      V_D_R8:  begin tgt = 2'b11; fmt = F_R8;  dual = 1'b1; end
      default: tgt = '0;
    endcase
  end

  // Holding-register load strobes and aligned data.
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      logic [HALF-1:0] h;
      if (!dual)
        h = wr_data[HALF-1:0];
      else if (fmt == F_R8)
        h = {{(HALF-BYTE){1'b0}}, wr_data[c*BYTE +: BYTE]};
      else
        h = wr_data[c*HALF +: HALF];
      ld[c]      = wr_en & tgt[c];
      ld_data[c] = align(fmt, h);
    end
  end

  // Control and software trigger next state.
  always_comb begin
    ctrl_we = wr_en && (view == V_CTRL);
    for (int c = 0; c < NCH; c++) begin
      ten_n[c]  = wr_data[c*CH_FIELD];
      tsel_n[c] = wr_data[c*CH_FIELD+1 +: SEL_W];
      sw_n[c]   = wr_en && (view == V_SWTRIG) && wr_data[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ten     <= '0;
      tsel    <= '0;
      sw_trig <= '0;
    end else begin
      if (ctrl_we) begin
        ten  <= ten_n;
        tsel <= tsel_n;
      end
      sw_trig <= sw_n;  // one-cycle pulse: cleared once its edge is seen
    end
  end

endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
  parameter int CODE_W = 12,
  parameter int SEL_W  = 4,
  parameter int LAT    = 3,
  localparam int NSRC  = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [CODE_W-1:0] ld_data,
  input  logic              ten,
  input  logic [SEL_W-1:0]  tsel,
  input  logic [NSRC-1:0]   src,
  output logic [CODE_W-1:0] hold_q,
  output logic [CODE_W-1:0] code,
  output logic              fire
);

  logic             sel_lvl;
  logic             src_prev;
  logic [LAT-1:0]   pipe;
  logic [LAT-1:0]   pipe_n;
  logic             xfer_en;

  assign sel_lvl = src[tsel];
  assign fire    = ten & sel_lvl & ~src_prev;

  generate
    if (LAT == 1) begin : g_lat1
      always_comb pipe_n = fire;
    end else begin : g_latn
      always_comb pipe_n = {pipe[LAT-2:0], fire};
    end
  endgenerate

  assign xfer_en = ~ten | pipe[LAT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      code     <= '0;
      src_prev <= 1'b0;
      pipe     <= '0;
    end else begin
      if (ld)      hold_q <= ld_data;
      if (xfer_en) code   <= hold_q;
      src_prev <= sel_lvl;
      pipe     <= pipe_n;
    end
  end

endmodule

// File: rtl/dac_xfer_ctrl.sv
module dac_xfer_ctrl
  import dac_xfer_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int SEL_W  = 4,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  parameter int LAT    = 3,
  localparam int NHW   = (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NHW-1:0]    hw_trig,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b
);

  logic [NCH-1:0]             ten_w;
  logic [NCH-1:0][SEL_W-1:0]  tsel_w;
  logic [NCH-1:0]             sw_w;
  logic [NCH-1:0]             ld_w;
  logic [NCH-1:0][CODE_W-1:0] ld_data_w;
  logic [NCH-1:0][CODE_W-1:0] hold_w;
  logic [NCH-1:0][CODE_W-1:0] code_w;
  logic [NCH-1:0]             fire_w;

  dac_regs #(
    .CODE_W(CODE_W), .SEL_W(SEL_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ten(ten_w), .tsel(tsel_w), .sw_trig(sw_w), .ld(ld_w), .ld_data(ld_data_w)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      dac_chan #(
        .CODE_W(CODE_W), .SEL_W(SEL_W), .LAT(LAT)
      ) u_ch (
        .clk(clk), .rst_n(rst_n),
        .ld(ld_w[c]), .ld_data(ld_data_w[c]),
        .ten(ten_w[c]), .tsel(tsel_w[c]),
        .src({hw_trig, sw_w[c]}),
        .hold_q(hold_w[c]), .code(code_w[c]), .fire(fire_w[c])
      );
    end
  endgenerate

  assign code_a = code_w[0];
  assign code_b = code_w[1];

endmodule

// File: rtl/dac_xfer_ctrl_chk.sv
module dac_xfer_ctrl_chk #(
  parameter int CODE_W = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              ten,
  input logic [1:0][CODE_W-1:0]  hold,
  input logic [1:0][CODE_W-1:0]  code,
  input logic [1:0]              fire
);

  generate
    for (genvar c = 0; c < 2; c++) begin : g_chk
      AST_UNTRIG_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ten[c] |=> code[c] == $past(hold[c])); // R2

      AST_XFER_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code[c]) |-> code[c] == $past(hold[c])); // R11

      AST_TRIG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fire[c], 3) |=> code[c] == $past(hold[c])); // R6

      AST_TRIG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ten[c] && !$past(fire[c], 3)) |=> $stable(code[c])); // R5
    end
  endgenerate

endmodule

bind dac_xfer_ctrl dac_xfer_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ten(ten_w), .hold(hold_w), .code(code_w), .fire(fire_w)
);

// File: tb/dac_xfer_ctrl_test.sv
module dac_xfer_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;
  logic [14:0] hw_trig;
  logic [11:0] code_a;
  logic [11:0] code_b;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  dac_xfer_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .hw_trig(hw_trig), .code_a(code_a), .code_b(code_b)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] idx, logic [31:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_idx = '0; wr_data = '0;
  endtask

  task automatic set_ctrl(logic ta, logic [3:0] sa, logic tb, logic [3:0] sb);
    wr(4'd0, {11'd0, sb, tb, 11'd0, sa, ta});
  endtask

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 code_a after reset", code_a, 12'h000);
    chk("R1 code_b after reset", code_b, 12'h000);
    hw_trig = '1; tick(5);
    chk("R1 code_a hw lines toggled", code_a, 12'h000);
    chk("R1 code_b hw lines toggled", code_b, 12'h000);
    hw_trig = '0; tick(2);
  endtask

  task automatic t_views;
    wr(4'd2, 32'hFFFF_F5A3); tick(1); chk("R3 A r12", code_a, 12'h5A3);
    wr(4'd3, 32'h0000_ABCD); tick(1); chk("R3 A l12", code_a, 12'hABC);
    wr(4'd4, 32'h0000_FF3C); tick(1); chk("R3 A r8", code_a, 12'h3C0);
    chk("R3 B untouched by A", code_b, 12'h000);
    wr(4'd5, 32'h0000_0E17); tick(1); chk("R3 B r12", code_b, 12'hE17);
    wr(4'd6, 32'h0000_1234); tick(1); chk("R3 B l12", code_b, 12'h123);
    wr(4'd7, 32'h0000_0099); tick(1); chk("R3 B r8", code_b, 12'h990);
    chk("R3 A untouched by B", code_a, 12'h3C0);
    wr(4'd8, 32'h0ABC_0123); tick(1);
    chk("R4 dual r12 A", code_a, 12'h123); chk("R4 dual r12 B", code_b, 12'hABC);
    wr(4'd9, 32'h7650_4320); tick(1);
    chk("R4 dual l12 A", code_a, 12'h432); chk("R4 dual l12 B", code_b, 12'h765);
    wr(4'd10, 32'h0000_C35A); tick(1);
    chk("R4 dual r8 A", code_a, 12'h5A0); chk("R4 dual r8 B", code_b, 12'hC30);
  endtask

  task automatic t_latency;
    wr(4'd2, 32'h0000_0111); tick(1);
    wr(4'd2, 32'h0000_02A5);
    chk("R2 not yet at write edge", code_a, 12'h111);
    tick(1);
    chk("R2 one edge after write", code_a, 12'h2A5);
  endtask

  task automatic t_unmapped;
    for (int i = 11; i < 16; i++) wr(4'(i), 32'hFFFF_FFFF);
    tick(2);
    chk("R11 unmapped A", code_a, 12'h2A5);
    chk("R11 unmapped B", code_b, 12'hC30);
  endtask

  task automatic t_hw;
    set_ctrl(1'b1, 4'd5, 1'b0, 4'd0);
    wr(4'd2, 32'h0000_0123); tick(2);
    chk("R5 held while enabled", code_a, 12'h2A5);
    hw_trig[4] = 1'b1; tick(3);
    chk("R6 before third edge", code_a, 12'h2A5);
    tick(1);
    chk("R6 at third edge", code_a, 12'h123);
    wr(4'd2, 32'h0000_0456); tick(6);
    chk("R7 level held high", code_a, 12'h123);
    hw_trig[3] = 1'b1; tick(5);
    chk("R7 unselected line", code_a, 12'h123);
    hw_trig = '0; tick(2);
  endtask

  task automatic t_late_data;
    hw_trig[4] = 1'b1; tick(1);
    wr(4'd2, 32'h0000_0222); tick(1);
    chk("R9 before transfer", code_a, 12'h123);
    tick(1);
    chk("R9 late value moved", code_a, 12'h222);
    hw_trig = '0; tick(2);
  endtask

  task automatic t_back2back;
    wr(4'd2, 32'h0000_00AA); tick(1);
    hw_trig[4] = 1'b1; tick(1);
    hw_trig[4] = 1'b0; tick(1);
    hw_trig[4] = 1'b1; tick(1);
    wr(4'd2, 32'h0000_00BB);
    chk("R10 first transfer", code_a, 12'h0AA);
    tick(1);
    chk("R10 between transfers", code_a, 12'h0AA);
    tick(1);
    chk("R10 second transfer", code_a, 12'h0BB);
    hw_trig = '0; tick(2);
  endtask

  task automatic t_sw;
    set_ctrl(1'b1, 4'd5, 1'b1, 4'd0);
    wr(4'd5, 32'h0000_07E5); tick(2);
    chk("R8 held before sw trigger", code_b, 12'hC30);
    wr(4'd1, 32'h0000_0002); tick(3);
    chk("R8 before fourth edge", code_b, 12'hC30);
    tick(1);
    chk("R8 at fourth edge", code_b, 12'h7E5);
    chk("R12 A unaffected by B sw", code_a, 12'h0BB);
    wr(4'd5, 32'h0000_01F0);
    wr(4'd1, 32'h0000_0002); tick(3);
    chk("R8 refire before", code_b, 12'h7E5);
    tick(1);
    chk("R8 refire after self-clear", code_b, 12'h1F0);
    wr(4'd2, 32'h0000_0300);
    hw_trig[4] = 1'b1; tick(4);
    chk("R12 A hw transfer", code_a, 12'h300);
    chk("R12 B unaffected by A hw", code_b, 12'h1F0);
    hw_trig = '0; tick(2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; hw_trig = '0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_views();
    t_latency();
    t_unmapped();
    t_hw();
    t_late_data();
    t_back2back();
    t_sw();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule